// File: doc/BRIEF.md
# Knock Pulse Event Counter

This block counts knock events arriving on an asynchronous, active-low sensor line. The line first passes through a chain of flip-flops that resolves metastability. A sample enable, produced by dividing the system clock by 48, then looks at the clean level. Each high-to-low change seen between two consecutive sample enables adds one to a 16-bit event counter. Software polls the count through a small read port. A byte read of the count address copies the whole live word into a holding register. The word read that follows returns that copy, so the two halves of one value are never mixed.

Software keeps only the upper 15 bits of the returned word and ignores the least significant bit. It finds the knock activity in an interval by subtracting successive readings. Any low pulse that lasts longer than one sample period is counted exactly once. A pulse that starts and ends between two sample enables is never seen. When the counter wraps past its top value, a sticky flag records the wrap. Reading the status address returns that flag and clears it.

Top module: `knock_event_counter`

## Requirements
- R1: After reset, the counter, the holding register, the overflow flag and rd_data are all zero.
- R2: A low pulse on knock_n that lasts longer than one sample period (DIV=48 clocks) increases the count by exactly one.
- R3: A low pulse that begins and ends between two sample enables leaves the count unchanged.
- R4: A line held low across many sample enables adds one count per falling transition. A line that is low from reset onwards counts once.
- R5: The sample enable is never active in two consecutive clock cycles.
- R6: The counter changes only by stepping up by exactly one, and it wraps from its top value to zero.
- R7: A byte read (rd_byte=1) at address 0 copies the live count into the holding register. In the next cycle it returns the upper byte of that copy in rd_data[7:0], with rd_data[15:8] zero.
- R8: A word read (rd_byte=0) at address 0 returns the holding register. Events counted after the copy do not change it until the next byte read at address 0.
- R9: When the counter wraps to zero, the overflow flag is set. A read of any width at address 1 returns the flag in rd_data[0], with all other bits zero, and clears it. A wrap in the same cycle as such a read keeps the flag set.
- R10: rd_data changes only in the cycle after an accepted read (rd_en=1), and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| knock_n | input | 1 | Asynchronous knock line, low while knock is present |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_byte | input | 1 | 1 = byte access, 0 = word access |
| rd_addr | input | 2 | 0 = count, 1 = overflow status |
| rd_data | output | 16 | Registered read data |

## Verification
The bench places a four-clock low pulse in the middle of a sample period. A design that detects levels instead of sampling them would count this pulse. It holds the line low for ten sample periods, which exposes a design that counts once per low sample rather than once per falling transition. It adds events between the copying byte read and the word read, which exposes a holding register that tracks the live count. A second, narrow instance is driven through a wrap. This shows whether the overflow flag is set on the wrap, whether it survives until it is read, and whether it clears after that read.

// File: rtl/kec_pkg.sv
package kec_pkg;

    localparam int REG_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADR_COUNT  = 2'd0,
        ADR_STATUS = 2'd1
    } kec_addr_e;

    typedef struct packed {
        logic       en;
        logic       byte_acc;
        logic [1:0] addr;
    } kec_rd_req_t;

    function automatic logic [REG_W-1:0] kec_hi_byte(input logic [REG_W-1:0] w);
        return {{(REG_W-BYTE_W){1'b0}}, w[REG_W-1 -: BYTE_W]};
    endfunction

endpackage

// File: rtl/kec_sync.sv
module kec_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/kec_tick_div.sv
module kec_tick_div #(
    parameter int DIV = 48
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5
endmodule

// File: rtl/kec_pulse_qual.sv
module kec_pulse_qual (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lvl,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)       prev_q <= 1'b1;
        else if (tick) prev_q <= lvl;
    end

    assign evt = tick && prev_q && !lvl;

    AST_EVT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R4
endmodule

// File: rtl/kec_regif.sv
module kec_regif
    import kec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  kec_rd_req_t       req,
    output logic [REG_W-1:0]  rd_data
);
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] snap_q;
    logic             ovf_q;
    logic             wrap;
    logic             cap;
    logic             stat_rd;
    logic [REG_W-1:0] live_w;

    assign wrap    = evt && (&cnt_q);
    assign cap     = req.en && req.byte_acc && (req.addr == ADR_COUNT);
    assign stat_rd = req.en && (req.addr == ADR_STATUS);
    assign live_w  = REG_W'(cnt_q);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (evt) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         ovf_q <= 1'b0;
        else if (wrap)   ovf_q <= 1'b1;
        else if (stat_rd) ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)      snap_q <= '0;
        else if (cap) snap_q <= live_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (req.en) begin
            case (req.addr)
                ADR_COUNT:  rd_data <= req.byte_acc ? kec_hi_byte(live_w) : snap_q;
                ADR_STATUS: rd_data <= {{(REG_W-1){1'b0}}, ovf_q};
                default:    rd_data <= '0;
            endcase
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(snap_q)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !stat_rd) |=> ovf_q); // R9
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !evt) |=> !ovf_q); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req.en |=> $stable(rd_data)); // R10
endmodule

// File: rtl/knock_event_counter.sv
module knock_event_counter
    import kec_pkg::*;
#(
    parameter int DIV         = 48,
    parameter int SYNC_STAGES = 3,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        knock_n,
    input  logic        rd_en,
    input  logic        rd_byte,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data
);
    logic        lvl_sync;
    logic        tick;
    logic        evt;
    kec_rd_req_t req;

    assign req = '{en: rd_en, byte_acc: rd_byte, addr: rd_addr};

    kec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(knock_n), .q(lvl_sync)
    );

    kec_tick_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .tick(tick)
    );

    kec_pulse_qual u_qual (
        .clk(clk), .rst(rst), .tick(tick), .lvl(lvl_sync), .evt(evt)
    );

    kec_regif #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .evt(evt), .req(req), .rd_data(rd_data)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 16'h0000)); // R1
endmodule

// File: tb/knock_event_counter_tb_top.sv
module knock_event_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        knock_n = 1'b1;
    logic        rd_en = 1'b0;
    logic        rd_byte = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;

    logic        knock_s = 1'b0;
    logic        rd_en_s = 1'b0;
    logic        rd_byte_s = 1'b0;
    logic [1:0]  rd_addr_s = 2'd0;
    logic [15:0] rd_data_s;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    knock_event_counter dut_i (
        .clk(clk), .rst(rst), .knock_n(knock_n), .rd_en(rd_en),
        .rd_byte(rd_byte), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    knock_event_counter #(.DIV(4), .SYNC_STAGES(3), .CNT_W(4)) dut_small_i (
        .clk(clk), .rst(rst), .knock_n(knock_s), .rd_en(rd_en_s),
        .rd_byte(rd_byte_s), .rd_addr(rd_addr_s), .rd_data(rd_data_s)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic bacc, input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_byte = bacc; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_s(input logic bacc, input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en_s = 1'b1; rd_byte_s = bacc; rd_addr_s = a;
        @(negedge clk);
        rd_en_s = 1'b0;
        d = rd_data_s;
    endtask

    task automatic pulse(input int low_cyc, input int high_cyc);
        @(negedge clk); knock_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        knock_n = 1'b1;
        repeat (high_cyc) @(negedge clk);
    endtask

    task automatic read_count(output logic [15:0] d);
        logic [15:0] b;
        rd(1'b1, 2'd0, b);
        rd(1'b0, 2'd0, d);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 rd_data after reset", rd_data, 16'h0000);
        rd(1'b0, 2'd0, d); check("R1 holding register", d, 16'h0000);
        rd(1'b0, 2'd1, d); check("R1 overflow flag", d, 16'h0000);
        read_count(d);     check("R1 live count", d, 16'h0000);
    endtask

    task automatic t_single();
        logic [15:0] d;
        pulse(60, 150);
        rd(1'b1, 2'd0, d); check("R7 byte read upper byte", d, 16'h0000);
        rd(1'b0, 2'd0, d); check("R2 one long pulse", d, 16'd1);
    endtask

    task automatic t_short();
        logic [15:0] d;
        while ((cyc % DIV) != 10) @(negedge clk);
        knock_n = 1'b0;
        repeat (4) @(negedge clk);
        knock_n = 1'b1;
        repeat (150) @(negedge clk);
        read_count(d); check("R3 short pulse ignored", d, 16'd1);
    endtask

    task automatic t_held();
        logic [15:0] d;
        pulse(DIV * 10, 150);
        read_count(d); check("R4 held low counts once", d, 16'd2);
        for (int i = 0; i < 3; i++) pulse(60, 60);
        repeat (100) @(negedge clk);
        read_count(d); check("R4 separate falls counted", d, 16'd5);
    endtask

    task automatic t_snap_hold();
        logic [15:0] d;
        logic [15:0] held;
        rd(1'b1, 2'd0, d);
        check("R10 rd_data holds between reads", rd_data, d);
        pulse(60, 150);
        check("R10 rd_data unchanged by events", rd_data, d);
        rd(1'b0, 2'd0, held); check("R8 copy not updated by new event", held, 16'd5);
        read_count(d);        check("R8 next byte read refreshes copy", d, 16'd6);
    endtask

    task automatic t_upper_byte();
        logic [15:0] d;
        for (int i = 0; i < 300; i++) pulse(50, 50);
        repeat (100) @(negedge clk);
        rd(1'b1, 2'd0, d); check("R7 upper byte of 306", d, 16'h0001);
        rd(1'b0, 2'd0, d); check("R2 count after burst", d, 16'd306);
        rd(1'b0, 2'd1, d); check("R9 no overflow yet", d, 16'h0000);
    endtask

    task automatic t_wrap();
        logic [15:0] d;
        read_count_s(d); check("R4 low from reset counts once", d, 16'd1);
        @(negedge clk); knock_s = 1'b1;
        repeat (12) @(negedge clk);
        for (int i = 0; i < 14; i++) begin
            knock_s = 1'b0; repeat (12) @(negedge clk);
            knock_s = 1'b1; repeat (12) @(negedge clk);
        end
        read_count_s(d); check("R6 count before wrap", d, 16'd15);
        rd_s(1'b0, 2'd1, d); check("R9 no overflow at 15", d, 16'h0000);
        knock_s = 1'b0; repeat (12) @(negedge clk);
        knock_s = 1'b1; repeat (12) @(negedge clk);
        read_count_s(d); check("R6 wrap to zero", d, 16'd0);
        repeat (20) @(negedge clk);
        rd_s(1'b1, 2'd1, d); check("R9 overflow flag set and sticky", d, 16'h0001);
        rd_s(1'b0, 2'd1, d); check("R9 overflow cleared by read", d, 16'h0000);
    endtask

    task automatic read_count_s(output logic [15:0] d);
        logic [15:0] b;
        rd_s(1'b1, 2'd0, b);
        rd_s(1'b0, 2'd0, d);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_short();
        t_held();
        t_snap_hold();
        t_upper_byte();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule